// File: doc/BRIEF.md
# DMA Request-to-Channel Mapper

This block sits between 75 peripheral DMA request lines and a bank of DMA channels. Each request line owns one small programmable map register that says whether the line is routed at all and, if it is, which channel it drives. Every clock the block samples all request lines. For each line that changed and is routed, it updates the target channel's request-active level and emits one-cycle strobes that the channel status block uses to set or clear its request-after-stop bit and to set its end-of-receive bit.

The map registers are reached over a simple register port whose reads are combinational. Requests 0 to 63 sit in a low address window and requests 64 to 74 in a separate high window. Three request-status words near the low window read as zero and ignore writes. A map write that names a channel beyond the configured channel count is stored, but it raises a sticky error flag, and requests routed that way produce no channel events.

Top module: `dreq_channel_mapper`

## Requirements
- R1: The map register of request n (n < 64) is at byte address 0x100 + 4n, and the map register of request n (64 <= n <= 74) is at 0x1100 + 4(n-64). A write stores the whole 8-bit byte, and a read returns it with reg_hit high. Bit 7 is the route-enable flag and bits 4:0 are the target channel.
- R2: Addresses 0xE0, 0xE4 and 0xE8 read as 0 with reg_hit high. Writes to them change no map register.
- R3: Any other address, including addresses with bits 1:0 not zero and 0x112C, reads 0 with reg_hit low. Writes to it change no map register.
- R4: A change on a request whose route-enable flag is clear produces no strobe and leaves every ch_active bit unchanged.
- R5: When a routed request rises while its channel's ch_active bit is 0, that channel's ras_set bit pulses for one cycle.
- R6: Every other update from a routed request (a rise while the channel is active, or any fall) pulses that channel's ras_clr bit.
- R7: When a routed request falls while its channel's ch_active bit is 1, that channel's eor_set bit pulses.
- R8: ch_active of a channel equals the latest value of the most recently changed request routed to it. It changes, together with the strobes, on the first clock edge that samples the request change, and it holds when no routed request changes.
- R9: When several routed requests change in the same cycle, they are applied in ascending request order. The strobes show the net result for each channel.
- R10: A map write with bit 7 set and a channel number of NUM_CH or more is stored and sets map_err, which stays set until reset. Requests routed that way produce no events. A write with bit 7 clear never sets map_err.
- R11: After reset every map register reads 0, and ch_active, all strobes and map_err are 0.
- R12: ras_set and ras_clr are never both high for the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_REQ (75) | Peripheral request levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| reg_hit | output | 1 | reg_addr decodes to a map or status register |
| ch_active | output | NUM_CH (16) | Per-channel request-active level |
| ras_set | output | NUM_CH (16) | Set strobe for the request-after-stop bit |
| ras_clr | output | NUM_CH (16) | Clear strobe for the request-after-stop bit |
| eor_set | output | NUM_CH (16) | Set strobe for the end-of-receive bit |
| map_err | output | 1 | Sticky flag for a routed map write to a missing channel |

## Verification
The hardest case to reach is two requests routed to the same channel that change in the same clock in opposite directions. Only in that case does the ascending processing order change the result, and the correct net strobes differ from those of the reverse order. The stimulus first routes two lines to one channel. It then steps them through single-line edges until one line is high and the channel is inactive, and toggles both lines in the same cycle. After that it swaps the roles of the two lines and toggles both again. A remap of a request that is still held high, followed by its fall on the new channel, covers the other case where the port-visible history alone does not predict the outcome.

// File: rtl/dcm_pkg.sv
`timescale 1ns/1ps
package dcm_pkg;
    localparam int ADDR_W          = 16;
    localparam int REG_W           = 8;
    localparam int CHAN_FIELD_W    = 5;
    localparam int ROUTE_BIT       = 7;
    localparam int IDX_W           = 7;
    localparam int LO_WINDOW_COUNT = 64;
    localparam int STAT_COUNT      = 3;
    localparam logic [ADDR_W-1:0] LO_WINDOW_BASE = 16'h0100;
    localparam logic [ADDR_W-1:0] HI_WINDOW_BASE = 16'h1100;
    localparam logic [ADDR_W-1:0] STAT_BASE      = 16'h00E0;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MAP  = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } reg_decode_t;

    // Word-aligned decode of the two map windows and the status words.
    function automatic reg_decode_t decode_addr(input logic [ADDR_W-1:0] addr,
                                                input int num_req);
        reg_decode_t d;
        int          off;
        d.sel = SEL_NONE;
        d.idx = '0;
        off   = 0;
        if (addr[1:0] == 2'b00) begin
            if (addr >= LO_WINDOW_BASE &&
                addr < LO_WINDOW_BASE + ADDR_W'(4 * LO_WINDOW_COUNT)) begin
                off = int'(addr - LO_WINDOW_BASE) >> 2;
                if (off < num_req) begin
                    d.sel = SEL_MAP;
                    d.idx = IDX_W'(off);
                end
            end else if (num_req > LO_WINDOW_COUNT && addr >= HI_WINDOW_BASE &&
                         addr < HI_WINDOW_BASE + ADDR_W'(4 * (num_req - LO_WINDOW_COUNT))) begin
                off   = LO_WINDOW_COUNT + (int'(addr - HI_WINDOW_BASE) >> 2);
                d.sel = SEL_MAP;
                d.idx = IDX_W'(off);
            end else if (addr >= STAT_BASE &&
                         addr < STAT_BASE + ADDR_W'(4 * STAT_COUNT)) begin
                d.sel = SEL_STAT;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/dcm_map_regs.sv
`timescale 1ns/1ps
module dcm_map_regs
    import dcm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     wr_en,
    input  logic [ADDR_W-1:0]                        addr,
    input  logic [REG_W-1:0]                         wdata,
    output logic [REG_W-1:0]                         rdata,
    output logic                                     hit,
    output logic [NUM_REQ-1:0]                       route_en,
    output logic [NUM_REQ-1:0][CHAN_FIELD_W-1:0]     route_chan,
    output logic                                     map_err
);
    logic [NUM_REQ-1:0][REG_W-1:0] map_q;
    reg_decode_t                   dec;
    logic                          chan_bad;
    logic                          map_wr;

    assign dec    = decode_addr(addr, NUM_REQ);
    assign map_wr = wr_en && (dec.sel == SEL_MAP);

    // A full 5-bit channel field needs no range check.
    generate
        if (NUM_CH >= (1 << CHAN_FIELD_W)) begin : g_full_range
            assign chan_bad = 1'b0;
        end else begin : g_part_range
            assign chan_bad = wdata[ROUTE_BIT] &&
                              (int'(wdata[CHAN_FIELD_W-1:0]) >= NUM_CH);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
        end else if (map_wr) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                if (dec.idx == IDX_W'(i)) map_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       map_err <= 1'b0;
        else if (map_wr && chan_bad)   map_err <= 1'b1;
    end

    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        case (dec.sel)
            SEL_MAP: begin
                rdata = map_q[dec.idx];
                hit   = 1'b1;
            end
            SEL_STAT: hit = 1'b1;
            default: ;
        endcase
    end

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_route
            assign route_en[g]   = map_q[g][ROUTE_BIT];
            assign route_chan[g] = map_q[g][CHAN_FIELD_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/dcm_event_engine.sv
`timescale 1ns/1ps
module dcm_event_engine
    import dcm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_REQ-1:0]                   req_in,
    input  logic [NUM_REQ-1:0]                   route_en,
    input  logic [NUM_REQ-1:0][CHAN_FIELD_W-1:0] route_chan,
    output logic [NUM_CH-1:0]                    ch_active,
    output logic [NUM_CH-1:0]                    ras_set,
    output logic [NUM_CH-1:0]                    ras_clr,
    output logic [NUM_CH-1:0]                    eor_set
);
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_REQ-1:0] req_q;
    logic [NUM_REQ-1:0] routable;
    logic [NUM_CH-1:0]  act_q, act_n, rs_n, rc_n, eo_n, rs_q, rc_q, eo_q;
    logic [CH_IDX_W-1:0] c;

    // A request takes part only when routed to an existing channel.
    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_routable
            if (NUM_CH >= (1 << CHAN_FIELD_W)) begin : g_any
                assign routable[g] = route_en[g];
            end else begin : g_limited
                assign routable[g] = route_en[g] && (int'(route_chan[g]) < NUM_CH);
            end
        end
    endgenerate

    // Changed requests are applied one after another, lowest index first.
    always_comb begin
        act_n = act_q;
        rs_n  = '0;
        rc_n  = '0;
        eo_n  = '0;
        c     = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            c = route_chan[i][CH_IDX_W-1:0];
            if (routable[i] && (req_in[i] != req_q[i])) begin
                if (req_in[i] && !act_n[c]) begin
                    rs_n[c] = 1'b1;
                    rc_n[c] = 1'b0;
                end else begin
                    rs_n[c] = 1'b0;
                    rc_n[c] = 1'b1;
                end
                if (!req_in[i] && act_n[c]) eo_n[c] = 1'b1;
                act_n[c] = req_in[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            act_q <= '0;
            rs_q  <= '0;
            rc_q  <= '0;
            eo_q  <= '0;
        end else begin
            req_q <= req_in;
            act_q <= act_n;
            rs_q  <= rs_n;
            rc_q  <= rc_n;
            eo_q  <= eo_n;
        end
    end

    assign ch_active = act_q;
    assign ras_set   = rs_q;
    assign ras_clr   = rc_q;
    assign eor_set   = eo_q;
endmodule

// File: rtl/dreq_channel_mapper.sv
`timescale 1ns/1ps
module dreq_channel_mapper
    import dcm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REQ-1:0]  req_in,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                reg_hit,
    output logic [NUM_CH-1:0]   ch_active,
    output logic [NUM_CH-1:0]   ras_set,
    output logic [NUM_CH-1:0]   ras_clr,
    output logic [NUM_CH-1:0]   eor_set,
    output logic                map_err
);
    logic [NUM_REQ-1:0]                   route_en;
    logic [NUM_REQ-1:0][CHAN_FIELD_W-1:0] route_chan;

    dcm_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .hit        (reg_hit),
        .route_en   (route_en),
        .route_chan (route_chan),
        .map_err    (map_err)
    );

    dcm_event_engine #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_events (
        .clk        (clk),
        .rst        (rst),
        .req_in     (req_in),
        .route_en   (route_en),
        .route_chan (route_chan),
        .ch_active  (ch_active),
        .ras_set    (ras_set),
        .ras_clr    (ras_clr),
        .eor_set    (eor_set)
    );
endmodule

// File: rtl/dcm_checker.sv
`timescale 1ns/1ps
module dcm_checker
    import dcm_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req_in,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [REG_W-1:0]   reg_rdata,
    input logic               reg_hit,
    input logic [NUM_CH-1:0]  ch_active,
    input logic [NUM_CH-1:0]  ras_set,
    input logic [NUM_CH-1:0]  ras_clr,
    input logic [NUM_CH-1:0]  eor_set,
    input logic               map_err
);
    logic warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    a_r12_set_clr_exclusive: assert property (@(posedge clk) disable iff (rst)
        (ras_set & ras_clr) == '0);

    a_r5_set_leaves_active: assert property (@(posedge clk) disable iff (rst)
        (ras_set & ~ch_active) == '0);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        map_err |=> map_err);

    a_r8_hold_without_change: assert property (@(posedge clk) disable iff (rst)
        (warm && (req_in == $past(req_in))) |=>
            (ras_set == '0 && ras_clr == '0 && eor_set == '0 && $stable(ch_active)));

    a_r2_status_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == STAT_BASE || reg_addr == STAT_BASE + 16'd4 ||
         reg_addr == STAT_BASE + 16'd8) |-> (reg_hit && reg_rdata == '0));

    a_r3_unaligned_miss: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[1:0] != 2'b00) |-> (!reg_hit && reg_rdata == '0));
endmodule

bind dreq_channel_mapper dcm_checker #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_dreq_channel_mapper.sv
`timescale 1ns/1ps
module sim_dreq_channel_mapper;
    localparam int NR = 75;
    localparam int NC = 16;
    localparam time CLK_PERIOD = 8ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] req_in = '0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          reg_hit;
    logic [NC-1:0] ch_active, ras_set, ras_clr, eor_set;
    logic          map_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    logic [7:0]    m_byte [NR];
    logic [NR-1:0] m_req = '0;
    logic [NC-1:0] m_act = '0, e_rs = '0, e_rc = '0, e_eo = '0;
    logic          m_err = 1'b0;
    logic [NR-1:0] cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    dreq_channel_mapper #(.NUM_REQ(NR), .NUM_CH(NC)) u0 (
        .clk(clk), .rst(rst), .req_in(req_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_hit(reg_hit), .ch_active(ch_active), .ras_set(ras_set),
        .ras_clr(ras_clr), .eor_set(eor_set), .map_err(map_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int map_index(input int a);
        if (a % 4 != 0) return -1;
        if (a >= 'h100 && a < 'h200) return (a - 'h100) / 4;
        if (a >= 'h1100 && a <= 'h1128) return 64 + (a - 'h1100) / 4;
        return -1;
    endfunction

    function automatic bit is_status(input int a);
        return a == 'hE0 || a == 'hE4 || a == 'hE8;
    endfunction

    task automatic model_events(input logic [NR-1:0] nr);
        e_rs = '0; e_rc = '0; e_eo = '0;
        for (int i = 0; i < NR; i++) begin
            int ch;
            ch = int'(m_byte[i][4:0]);
            if (nr[i] != m_req[i] && m_byte[i][7] && ch < NC) begin
                if (nr[i] && !m_act[ch]) begin e_rs[ch] = 1; e_rc[ch] = 0; end
                else begin e_rc[ch] = 1; e_rs[ch] = 0; end
                if (!nr[i] && m_act[ch]) e_eo[ch] = 1;
                m_act[ch] = nr[i];
            end
        end
        m_req = nr;
    endtask

    task automatic compare_all();
        chk("R8 ch_active", 32'(ch_active), 32'(m_act));
        chk("R5 ras_set", 32'(ras_set), 32'(e_rs));
        chk("R6 ras_clr", 32'(ras_clr), 32'(e_rc));
        chk("R7 eor_set", 32'(eor_set), 32'(e_eo));
        chk("R10 map_err", 32'(map_err), 32'(m_err));
    endtask

    task automatic step(input logic [NR-1:0] nr, input bit w,
                        input logic [15:0] a, input logic [7:0] d);
        int idx;
        model_events(nr);
        if (w) begin
            idx = map_index(int'(a));
            if (idx >= 0) begin
                m_byte[idx] = d;
                if (d[7] && int'(d[4:0]) >= NC) m_err = 1'b1;
            end
        end
        req_in = nr; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        step(cur, 1'b1, a, d);
    endtask

    task automatic setreq(input int i, input logic v);
        cur[i] = v;
        step(cur, 1'b0, 16'h0, 8'h0);
    endtask

    task automatic rd(input string tag, input logic [15:0] a);
        int idx;
        logic [7:0] ed;
        logic eh;
        idx = map_index(int'(a));
        ed = (idx >= 0) ? m_byte[idx] : 8'h00;
        eh = (idx >= 0) || is_status(int'(a));
        reg_addr = a;
        #1;
        chk({tag, " rdata"}, 32'(reg_rdata), 32'(ed));
        chk({tag, " hit"}, 32'(reg_hit), 32'(eh));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R8 watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NR; i++) m_byte[i] = 8'h00;
        cur = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R11: reset state
        compare_all();
        chk("R11 active", 32'(ch_active), 32'h0);
        chk("R11 err", 32'(map_err), 32'h0);
        rd("R11 map0", 16'h0100);
        rd("R11 map74", 16'h1128);

        // R1: both windows, full byte stored
        wr(16'h0100, 8'h80);          // req0 -> ch0
        wr(16'h0104, 8'h01);          // req1 not routed
        wr(16'h010C, 8'h82);          // req3 -> ch2
        wr(16'h0128, 8'h82);          // req10 -> ch2
        wr(16'h0114, 8'h62);          // req5 spare bits, not routed
        wr(16'h1100, 8'h8F);          // req64 -> ch15
        wr(16'h1118, 8'h85);          // req70 -> ch5
        wr(16'h1128, 8'h89);          // req74 -> ch9
        rd("R1 lo", 16'h010C);
        rd("R1 spare", 16'h0114);
        chk("R1 spare literal", 32'(reg_rdata), 32'h62);
        rd("R1 hi", 16'h1128);
        chk("R1 hi literal", 32'(reg_rdata), 32'h89);
        rd("R1 hi first", 16'h1100);
        rd("R1 lo last", 16'h01FC);

        // R3: unmapped and unaligned
        rd("R3 past hi", 16'h112C);
        rd("R3 unaligned", 16'h0101);
        rd("R3 gap", 16'h0200);
        wr(16'h010D, 8'h00);
        wr(16'h112C, 8'h81);
        rd("R3 write ignored", 16'h010C);
        chk("R3 map3 literal", 32'(reg_rdata), 32'h82);

        // R2: status words
        rd("R2 e0", 16'h00E0);
        rd("R2 e8", 16'h00E8);
        wr(16'h00E4, 8'hFF);
        rd("R2 e4", 16'h00E4);
        chk("R2 e4 literal", 32'(reg_rdata), 32'h00);
        rd("R2 map0 kept", 16'h0100);

        // R4: unrouted request
        setreq(1, 1'b1);
        chk("R4 no strobe", 32'(ras_set | ras_clr | eor_set), 32'h0);
        chk("R4 active", 32'(ch_active), 32'h0);
        setreq(1, 1'b0);

        // R5 / R6 / R7 / R8
        setreq(0, 1'b1);
        chk("R5 ch0 set", 32'(ras_set[0]), 32'h1);
        setreq(3, 1'b1);
        chk("R5 ch2 set", 32'(ras_set[2]), 32'h1);
        setreq(10, 1'b1);
        chk("R6 rise while active", 32'(ras_clr[2]), 32'h1);
        chk("R7 no eor on rise", 32'(eor_set[2]), 32'h0);
        setreq(10, 1'b0);
        chk("R7 eor on fall", 32'(eor_set[2]), 32'h1);
        chk("R8 follows latest", 32'(ch_active[2]), 32'h0);
        step(cur, 1'b0, 16'h0, 8'h0);
        chk("R8 idle hold", 32'(ras_set | ras_clr | eor_set), 32'h0);
        setreq(3, 1'b0);
        chk("R6 fall inactive", 32'(ras_clr[2]), 32'h1);
        chk("R7 no eor inactive", 32'(eor_set[2]), 32'h0);

        // R9: simultaneous changes on one channel
        setreq(10, 1'b1);
        setreq(3, 1'b1);
        setreq(3, 1'b0);               // req10=1, req3=0, ch2 inactive
        cur[3] = 1'b1; cur[10] = 1'b0;
        step(cur, 1'b0, 16'h0, 8'h0);
        chk("R9 a set", 32'(ras_set[2]), 32'h0);
        chk("R9 a clr", 32'(ras_clr[2]), 32'h1);
        chk("R9 a eor", 32'(eor_set[2]), 32'h1);
        chk("R9 a active", 32'(ch_active[2]), 32'h0);
        cur[3] = 1'b0; cur[10] = 1'b1;
        step(cur, 1'b0, 16'h0, 8'h0);
        chk("R9 b set", 32'(ras_set[2]), 32'h1);
        chk("R9 b clr", 32'(ras_clr[2]), 32'h0);
        chk("R9 b eor", 32'(eor_set[2]), 32'h0);
        chk("R9 b active", 32'(ch_active[2]), 32'h1);

        // R1: high-window requests, two channels in one cycle
        setreq(70, 1'b1);
        chk("R1 req70 ch5", 32'(ras_set), 32'h0020);
        cur[64] = 1'b1; cur[74] = 1'b1;
        step(cur, 1'b0, 16'h0, 8'h0);
        chk("R1 req64 req74", 32'(ras_set), 32'h8200);

        // Remap a held request, then release it
        wr(16'h0100, 8'h83);
        setreq(0, 1'b0);
        chk("R6 remapped fall", 32'(ras_clr), 32'h0008);
        chk("R8 old channel kept", 32'(ch_active[0]), 32'h1);

        // R10: channel beyond count
        wr(16'h0154, 8'h1F);
        chk("R10 unrouted no err", 32'(map_err), 32'h0);
        wr(16'h0150, 8'h94);
        chk("R10 err set", 32'(map_err), 32'h1);
        rd("R10 stored", 16'h0150);
        setreq(20, 1'b1);
        chk("R10 ignored", 32'(ras_set | ras_clr | eor_set), 32'h0);
        wr(16'h0150, 8'h00);
        step(cur, 1'b0, 16'h0, 8'h0);
        chk("R10 sticky", 32'(map_err), 32'h1);
        chk("R12 exclusive", 32'(ras_set & ras_clr), 32'h0);

        finish_run();
    end
endmodule